// File: doc/BRIEF.md
# Bus-Master DMA Control and Status Registers

This block holds the software-visible control state of a bus-mastering disk-interface DMA engine. Software reaches it over a byte-wide register bus: one write strobe, a 3-bit byte address, write data, and combinational read data. It keeps a command register with a start bit and a direction bit, a 32-bit descriptor-table base pointer, and a status register. The status register mixes engine-driven flags with two per-drive "DMA capable" bits that software owns.

The DMA engine drives pulse inputs that set the active, error and interrupt flags. It also drives a completion pulse that drops the active flag. Software starts a transfer by setting the start bit, and it clears the error and interrupt flags by writing ones to them. A clean-completion output tells the surrounding logic whether the finished transfer was good. A pending output marks the case where the engine is active and still busy. The block moves no data and fetches no descriptors.

Top module: `dmar_regs`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, and `xfer_start`, `xfer_to_mem`, `table_base`, `xfer_clean` and `xfer_pending` are all 0.
- R2: Byte 0 is the command register.
  - Bit 0 is start and bit 3 is direction (1 = transfer into memory). The other bits read 0.
  - A write stores both bits.
  - `xfer_start` and `xfer_to_mem` show the stored bits.
- R3: Bytes 4 to 7 hold the descriptor-table base pointer, least significant byte at 4. Each byte is readable and shows on `table_base`. A byte keeps its value until it is written.
- R4: Byte 2 is the status register, with these bits:
  - bit 0: active
  - bit 1: error
  - bit 2: interrupt
  - bits 5 and 6: capability flags for drive 0 and drive 1
  - Other bits read 0.
  - A status write stores bits 6:5, and they hold between writes.
  - Software cannot change bit 0.
- R5: Writing 1 to status bit 1 or bit 2 clears that flag, and writing 0 leaves it unchanged. Writing back the value just read, with bits 1 and 2 forced to 1, clears both flags and keeps the capability bits.
- R6: A pulse on `eng_error_set` or `eng_irq_set` sets its flag. When a set pulse and a write-one-to-clear hit a flag in the same cycle, the flag ends up set.
- R7: A pulse on `eng_active_set` sets the active flag. The flag is cleared on the next edge in either of two cases:
  - `eng_done` pulses, or
  - a command write clears a start bit that was 1.
  - A clear beats a set in the same cycle.
- R8: `xfer_clean` is 1 exactly when, of active, error and interrupt, only interrupt is set.
- R9: `xfer_pending` is 1 when the active flag is set and `eng_busy` is high. In that state `xfer_clean` is 0.
- R10: Addresses 1 and 3 read 0x00, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Byte address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| eng_active_set | input | 1 | Engine pulse: set active |
| eng_error_set | input | 1 | Engine pulse: set error |
| eng_irq_set | input | 1 | Engine pulse: set interrupt |
| eng_done | input | 1 | Engine pulse: transfer complete, clears active |
| eng_busy | input | 1 | Engine still moving data |
| xfer_start | output | 1 | Stored start bit |
| xfer_to_mem | output | 1 | Stored direction bit (1 = into memory) |
| table_base | output | 32 | Descriptor-table base pointer |
| xfer_clean | output | 1 | Clean completion status |
| xfer_pending | output | 1 | Active and still busy |

## Verification
The assertions check on every cycle the properties that hold from one edge to the next:
- a command write is stored;
- a write-one-to-clear with no competing set clears the error flag;
- an interrupt set pulse always wins;
- completion or a stop drops the active flag;
- the capability bits and the pointer stay stable unless written, and writes to unmapped addresses change nothing.

Only the bench's scenarios can show the complete register images:
- the read-modify-write sequence that clears both flags while keeping the capability bits;
- the exact bit positions seen on the read port;
- the clean and pending output values after a full start, interrupt and stop sequence.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int PTR_BYTES = 4;
    localparam int PTR_W     = DATA_W * PTR_BYTES;
    localparam int PSEL_W    = $clog2(PTR_BYTES);

    localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACT_BIT    = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_IRQ_BIT    = 2;
    localparam int ST_CAP_LO     = 5;

    typedef struct packed {
        logic to_mem;
        logic start;
    } cmd_t;

    typedef struct packed {
        logic [1:0] cap;
        logic       irq;
        logic       err;
        logic       active;
    } stat_t;

    typedef struct packed {
        logic active_set;
        logic error_set;
        logic irq_set;
        logic done;
    } eng_ev_t;

    function automatic logic [DATA_W-1:0] cmd_image(cmd_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CMD_START_BIT] = c.start;
        v[CMD_DIR_BIT]   = c.to_mem;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] stat_image(stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[ST_ACT_BIT] = s.active;
        v[ST_ERR_BIT] = s.err;
        v[ST_IRQ_BIT] = s.irq;
        v[ST_CAP_LO +: 2] = s.cap;
        return v;
    endfunction

    function automatic logic is_clean(stat_t s);
        return s.irq && !s.err && !s.active;
    endfunction

    function automatic logic is_ptr_addr(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/dmar_cmd_reg.sv
module dmar_cmd_reg
    import dmar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_cmd,
    input  logic wd_start,
    input  logic wd_to_mem,
    output cmd_t cmd,
    output logic stop_req
);

    assign stop_req = wr_cmd && cmd.start && !wd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (wr_cmd) begin
            cmd.start  <= wd_start;
            cmd.to_mem <= wd_to_mem;
        end
    end

    // R2
    cmd_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> (cmd.start == $past(wd_start)) && (cmd.to_mem == $past(wd_to_mem)));

endmodule

// File: rtl/dmar_status_reg.sv
module dmar_status_reg
    import dmar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stat,
    input  logic [6:1] wbits,
    input  eng_ev_t    ev,
    input  logic       stop_req,
    output stat_t      st
);

    stat_t st_nx;

    always_comb begin
        st_nx = st;
        if (ev.done || stop_req)
            st_nx.active = 1'b0;
        else if (ev.active_set)
            st_nx.active = 1'b1;

        if (ev.error_set)
            st_nx.err = 1'b1;
        else if (wr_stat && wbits[ST_ERR_BIT])
            st_nx.err = 1'b0;

        if (ev.irq_set)
            st_nx.irq = 1'b1;
        else if (wr_stat && wbits[ST_IRQ_BIT])
            st_nx.irq = 1'b0;

        if (wr_stat)
            st_nx.cap = wbits[ST_CAP_LO +: 2];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end

    // R5
    err_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wbits[ST_ERR_BIT] && !ev.error_set) |=> !st.err);

    // R6
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ev.irq_set |=> st.irq);

    // R7
    active_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.done || stop_req) |=> !st.active);

    // R4
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> $stable(st.cap));

endmodule

// File: rtl/dmar_base_ptr.sv
module dmar_base_ptr
    import dmar_pkg::*;
#(
    parameter int NBYTES = PTR_BYTES,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ptr,
    input  logic [SEL_W-1:0]     sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [8*NBYTES-1:0]  base
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                base[8*b +: 8] <= '0;
            else if (wr_ptr && (sel == SEL_W'(b)))
                base[8*b +: 8] <= wdata;
        end
    end

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ptr |=> $stable(base));

endmodule

// File: rtl/dmar_regs.sv
module dmar_regs
    import dmar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_active_set,
    input  logic              eng_error_set,
    input  logic              eng_irq_set,
    input  logic              eng_done,
    input  logic              eng_busy,
    output logic              xfer_start,
    output logic              xfer_to_mem,
    output logic [PTR_W-1:0]  table_base,
    output logic              xfer_clean,
    output logic              xfer_pending
);

    cmd_t    cmd;
    stat_t   st;
    eng_ev_t ev;
    logic    wr_cmd, wr_stat, wr_ptr, stop_req, wr_unmapped;

    assign wr_cmd      = reg_wr && (reg_addr == ADDR_CMD);
    assign wr_stat     = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_ptr      = reg_wr && is_ptr_addr(reg_addr);
    assign wr_unmapped = reg_wr && !wr_cmd && !wr_stat && !wr_ptr;

    assign ev = '{active_set: eng_active_set, error_set: eng_error_set,
                  irq_set: eng_irq_set, done: eng_done};

    dmar_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .wd_start  (reg_wdata[CMD_START_BIT]),
        .wd_to_mem (reg_wdata[CMD_DIR_BIT]),
        .cmd       (cmd),
        .stop_req  (stop_req)
    );

    dmar_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (wr_stat),
        .wbits    (reg_wdata[6:1]),
        .ev       (ev),
        .stop_req (stop_req),
        .st       (st)
    );

    dmar_base_ptr #(.NBYTES(PTR_BYTES)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .wr_ptr (wr_ptr),
        .sel    (reg_addr[PSEL_W-1:0]),
        .wdata  (reg_wdata),
        .base   (table_base)
    );

    always_comb begin
        reg_rdata = '0;
        if (is_ptr_addr(reg_addr))
            reg_rdata = table_base[{reg_addr[PSEL_W-1:0], 3'b000} +: 8];
        else if (reg_addr == ADDR_CMD)
            reg_rdata = cmd_image(cmd);
        else if (reg_addr == ADDR_STAT)
            reg_rdata = stat_image(st);
    end

    assign xfer_start   = cmd.start;
    assign xfer_to_mem  = cmd.to_mem;
    assign xfer_clean   = is_clean(st);
    assign xfer_pending = st.active && eng_busy;

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_unmapped && !eng_active_set && !eng_error_set && !eng_irq_set && !eng_done)
        |=> $stable(table_base) && $stable(xfer_start) && $stable(xfer_to_mem)
            && $stable(st));

    // R9
    pending_not_clean_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_pending |-> !xfer_clean);

endmodule

// File: tb/dmar_regs_test.sv
`timescale 1ns/1ps
module dmar_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        eng_active_set = 1'b0, eng_error_set = 1'b0;
    logic        eng_irq_set = 1'b0, eng_done = 1'b0, eng_busy = 1'b0;
    logic        xfer_start, xfer_to_mem, xfer_clean, xfer_pending;
    logic [31:0] table_base;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dmar_regs uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_active_set(eng_active_set), .eng_error_set(eng_error_set),
        .eng_irq_set(eng_irq_set), .eng_done(eng_done), .eng_busy(eng_busy),
        .xfer_start(xfer_start), .xfer_to_mem(xfer_to_mem),
        .table_base(table_base), .xfer_clean(xfer_clean),
        .xfer_pending(xfer_pending)
    );

    // vector: {we, waddr, wdata, {done,irq,err,act}, raddr, expected}
    localparam int NV = 14;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'h09, 4'b0000, 3'd0, 8'h09},
        {1'b1, 3'd0, 8'hFF, 4'b0000, 3'd0, 8'h09},
        {1'b1, 3'd4, 8'h78, 4'b0000, 3'd4, 8'h78},
        {1'b1, 3'd7, 8'h12, 4'b0000, 3'd7, 8'h12},
        {1'b1, 3'd2, 8'h67, 4'b0000, 3'd2, 8'h60},
        {1'b0, 3'd0, 8'h00, 4'b0101, 3'd2, 8'h65},
        {1'b0, 3'd0, 8'h00, 4'b0010, 3'd2, 8'h67},
        {1'b1, 3'd2, 8'h67, 4'b0000, 3'd2, 8'h61},
        {1'b0, 3'd0, 8'h00, 4'b1000, 3'd2, 8'h60},
        {1'b1, 3'd2, 8'h20, 4'b0000, 3'd2, 8'h20},
        {1'b1, 3'd2, 8'h24, 4'b0100, 3'd2, 8'h24},
        {1'b1, 3'd1, 8'hFF, 4'b0000, 3'd1, 8'h00},
        {1'b0, 3'd0, 8'h00, 4'b0001, 3'd2, 8'h25},
        {1'b1, 3'd0, 8'h08, 4'b0000, 3'd2, 8'h24}
    };
    localparam string VTAG [NV] = '{
        "R2", "R2", "R3", "R3", "R4", "R6", "R6",
        "R5", "R7", "R4", "R6", "R10", "R7", "R7"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic [3:0] hw);
        reg_wr = we; reg_addr = a; reg_wdata = d;
        {eng_done, eng_irq_set, eng_error_set, eng_active_set} = hw;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        {eng_done, eng_irq_set, eng_error_set, eng_active_set} = 4'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        read_chk("R1", 3'd0, 8'h00);
        read_chk("R1", 3'd2, 8'h00);
        read_chk("R1", 3'd5, 8'h00);
        check("R1", {27'h0, xfer_start, xfer_to_mem, xfer_clean, xfer_pending, 1'b0}, 32'h0);
        check("R1", table_base, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26], VEC[i][25:23], VEC[i][22:15], VEC[i][14:11]);
            read_chk(VTAG[i], VEC[i][10:8], VEC[i][7:0]);
        end

        // R2 outputs after stop write of 0x08
        check("R2", {30'h0, xfer_start, xfer_to_mem}, 32'h1);
        read_chk("R10", 3'd0, 8'h08);
        // R3 assembled pointer
        check("R3", table_base, 32'h1200_0078);
        // R8 only interrupt set
        check("R8", {31'h0, xfer_clean}, 32'h1);
        step(1'b0, 3'd0, 8'h00, 4'b0010);
        check("R8", {31'h0, xfer_clean}, 32'h0);
        // R5 clear both flags by forced readback
        step(1'b1, 3'd2, 8'h26, 4'b0000);
        read_chk("R5", 3'd2, 8'h20);
        // R9 active with busy engine
        eng_busy = 1'b1;
        step(1'b0, 3'd0, 8'h00, 4'b0101);
        check("R9", {30'h0, xfer_pending, xfer_clean}, 32'h2);
        eng_busy = 1'b0;
        #1;
        check("R9", {31'h0, xfer_pending}, 32'h0);
        // R7 done and set together: clear wins
        step(1'b0, 3'd0, 8'h00, 4'b1001);
        read_chk("R7", 3'd2, 8'h24);
        // R1 reset again
        rst = 1'b1;
        step(1'b0, 3'd0, 8'h00, 4'b0000);
        rst = 1'b0;
        read_chk("R1", 3'd2, 8'h00);
        check("R1", table_base, 32'h0);
        finish_run();
    end

endmodule